// File: doc/BRIEF.md
# Boot ROM Overlay Address Decoder

This block is the memory-map decoder that lets an on-chip boot program sit in front of the low part of the cartridge address space after reset. Every CPU address is decoded against one or two overlay windows. While the overlay is active, a read that lands in a window gets its data from the internal boot ROM. Every other read gets its data from the cartridge bus. The block also computes the index into the boot ROM array. The decoder has no pipeline stage: the source choice and the returned data follow the current address in the same cycle.

The boot program ends by writing to a one-way I/O register that removes the overlay for good. From the next cycle on, the low addresses return cartridge data. The register ignores all later writes, and only a reset brings the overlay back. A parameter picks the variant:
- Single window: 256 bytes at the bottom of the map.
- Two windows: a second 1792-byte window at 0x0200 to 0x08FF. Between the two windows, 0x0100 to 0x01FF stays on the cartridge so that the header there can always be read.

Top module: `boot_overlay_decoder`

## Requirements
- R1: After reset the overlay is active, and a read of address 0x0000 returns boot ROM data, with `boot_sel` high.
- R2: While the overlay is active, an address in 0x0000 to 0x00FF sets `boot_sel`. `boot_addr` equals the address, and `cpu_rdata` equals `boot_rdata`.
- R3: A write to 0xFF50 whose data has bit 0 set removes the overlay. In the next cycle, reads of 0x0000 to 0x00FF return `cart_rdata` with `boot_sel` low.
- R4: These writes leave the overlay unchanged:
  - a write to 0xFF50 with bit 0 of the data clear;
  - a write to any other address, including the addresses inside the windows.
- R5: Once the overlay is removed, further writes to 0xFF50 of any value do not restore it. Only reset restores it.
- R6: In the two-window variant, with the overlay active, addresses 0x0200 to 0x08FF set `boot_sel`. `boot_addr` equals the address minus 0x0100, which maps 0x0200 to 0x100 and 0x08FF to 0x7FF.
- R7: These addresses always select the cartridge:
  - 0x0100 to 0x01FF in both variants;
  - 0x0900 and above;
  - in the single-window variant, 0x0200 to 0x08FF.
- R8: A write is never routed to the boot ROM. `cart_wr` follows `cpu_wr` for every address except 0xFF50, where it stays low.
- R9: The source choice and `cpu_rdata` are combinational in the address and the registered flag. A new address yields its data in the same cycle.
- R10: `cart_rd` equals `cpu_rd` when the cartridge is the source and is low when the boot ROM is the source.

Parameter `DUAL_WINDOW` selects the variant (1 = two windows, 0 = single window). When `boot_sel` is low, `boot_addr` carries no meaning.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, restores the overlay |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| boot_addr | output | 11 | Index into the boot ROM array |
| boot_rdata | input | 8 | Data from the boot ROM array at `boot_addr` |
| boot_sel | output | 1 | High when the boot ROM is the source for this address |
| cart_rd | output | 1 | Read strobe to the cartridge bus |
| cart_wr | output | 1 | Write strobe to the cartridge bus |
| cart_rdata | input | 8 | Data from the cartridge bus |

## Verification
Results fall into two groups by timing:
- **Same cycle.** Source choice, read data, ROM index and strobes belong to the cycle in which the address is presented. The bench checks them a quarter period after the driving edge, before the next rising edge.
- **Next cycle.** Removing the overlay takes effect only from the rising edge that captures the write. The bench model updates its flag after checking the write cycle itself, so the read that follows is the first one expected to return cartridge data.

Both variants run from the same stimulus, side by side.

// File: rtl/bootmap_pkg.sv
package bootmap_pkg;
   typedef enum logic {
      SRC_CART = 1'b0,
      SRC_BOOT = 1'b1
   } bootmap_src_e;

   typedef struct packed {
      logic reg_hit;
      logic arm_hit;
   } bootmap_wdec_t;

   function automatic int unsigned bootmap_clog2(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((32'd1 << r) < v) r++;
      return r;
   endfunction
endpackage

// File: rtl/bootmap_window.sv
module bootmap_window #(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned IDX_W    = 11,
   parameter int unsigned BASE     = 0,
   parameter int unsigned SIZE     = 256,
   parameter int unsigned IDX_BASE = 0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [IDX_W-1:0]  idx
);
   localparam logic [ADDR_W:0]   LO_X   = (ADDR_W+1)'(BASE);
   localparam logic [ADDR_W:0]   HI_X   = (ADDR_W+1)'(BASE + SIZE);
   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
   localparam logic [IDX_W-1:0]  IBASE  = IDX_W'(IDX_BASE);

   if (SIZE == 0) begin : g_bad_size
      $error("bootmap_window: SIZE must be nonzero");
   end
   if ((BASE + SIZE) > (1 << ADDR_W)) begin : g_bad_span
      $error("bootmap_window: window runs past the address space");
   end
   if ((IDX_BASE + SIZE) > (1 << IDX_W)) begin : g_bad_idx
      $error("bootmap_window: window runs past the ROM index range");
   end

   logic [ADDR_W:0] addr_x;
   logic [IDX_W-1:0] offs;

   always_comb begin
      addr_x = {1'b0, addr};
      hit    = (addr_x >= LO_X) && (addr_x < HI_X);
      offs   = IDX_W'(addr - BASE_A);
      idx    = offs + IBASE;
   end
endmodule

// File: rtl/bootmap_unmap_reg.sv
module bootmap_unmap_reg
   import bootmap_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned REG_ADDR = 16'hFF50,
   parameter int unsigned ARM_MASK = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output bootmap_wdec_t     wdec,
   output logic              overlay_on
);
   localparam logic [ADDR_W-1:0] REG_A  = ADDR_W'(REG_ADDR);
   localparam logic [DATA_W-1:0] MASK_D = DATA_W'(ARM_MASK);

   if (ARM_MASK == 0) begin : g_bad_mask
      $error("bootmap_unmap_reg: ARM_MASK must select at least one bit");
   end
   if (REG_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("bootmap_unmap_reg: REG_ADDR outside the address space");
   end

   always_comb begin
      wdec.reg_hit = wr && (addr == REG_A);
      wdec.arm_hit = wdec.reg_hit && ((wdata & MASK_D) != '0);
   end

   // One-way flag: it can only fall, and reset alone raises it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         overlay_on <= 1'b1;
      end else if (overlay_on && wdec.arm_hit) begin
         overlay_on <= 1'b0;
      end
   end
endmodule

// File: rtl/bootmap_rdata_mux.sv
module bootmap_rdata_mux
   import bootmap_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  bootmap_src_e      src,
   input  logic              rd,
   input  logic [DATA_W-1:0] boot_rdata,
   input  logic [DATA_W-1:0] cart_rdata,
   output logic [DATA_W-1:0] rdata,
   output logic              cart_rd
);
   always_comb begin
      unique case (src)
         SRC_BOOT: begin
            rdata   = boot_rdata;
            cart_rd = 1'b0;
         end
         default: begin
            rdata   = cart_rdata;
            cart_rd = rd;
         end
      endcase
   end
endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder
   import bootmap_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned BOOT_AW     = 11,
   parameter bit          DUAL_WINDOW = 1'b1,
   parameter int unsigned LOW_BASE    = 16'h0000,
   parameter int unsigned LOW_SIZE    = 256,
   parameter int unsigned HIGH_BASE   = 16'h0200,
   parameter int unsigned HIGH_SIZE   = 1792,
   parameter int unsigned UNMAP_ADDR  = 16'hFF50,
   parameter int unsigned UNMAP_MASK  = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  cpu_addr,
   input  logic               cpu_rd,
   input  logic               cpu_wr,
   input  logic [DATA_W-1:0]  cpu_wdata,
   output logic [DATA_W-1:0]  cpu_rdata,
   output logic [BOOT_AW-1:0] boot_addr,
   input  logic [DATA_W-1:0]  boot_rdata,
   output logic               boot_sel,
   output logic               cart_rd,
   output logic               cart_wr,
   input  logic [DATA_W-1:0]  cart_rdata
);
   localparam int unsigned ROM_BYTES = DUAL_WINDOW ? (LOW_SIZE + HIGH_SIZE) : LOW_SIZE;
   localparam int unsigned NEED_AW   = bootmap_clog2(ROM_BYTES);
   localparam int unsigned HIGH_IDX  = LOW_SIZE;

   if (NEED_AW > BOOT_AW) begin : g_bad_aw
      $error("boot_overlay_decoder: BOOT_AW too narrow for the overlay");
   end
   if (DUAL_WINDOW && (HIGH_BASE < LOW_BASE + LOW_SIZE)) begin : g_bad_order
      $error("boot_overlay_decoder: high window must lie above the low window");
   end
   if ((UNMAP_ADDR >= LOW_BASE) && (UNMAP_ADDR < LOW_BASE + LOW_SIZE)) begin : g_bad_reg
      $error("boot_overlay_decoder: register address inside the overlay");
   end

   logic               overlay_on;
   bootmap_wdec_t      wdec;
   logic               low_hit;
   logic [BOOT_AW-1:0] low_idx;
   logic               high_hit;
   logic [BOOT_AW-1:0] high_idx;
   bootmap_src_e       src;

   bootmap_unmap_reg #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .REG_ADDR (UNMAP_ADDR),
      .ARM_MASK (UNMAP_MASK)
   ) u_unmap (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr       (cpu_addr),
      .wr         (cpu_wr),
      .wdata      (cpu_wdata),
      .wdec       (wdec),
      .overlay_on (overlay_on)
   );

   bootmap_window #(
      .ADDR_W   (ADDR_W),
      .IDX_W    (BOOT_AW),
      .BASE     (LOW_BASE),
      .SIZE     (LOW_SIZE),
      .IDX_BASE (0)
   ) u_low_win (
      .addr (cpu_addr),
      .hit  (low_hit),
      .idx  (low_idx)
   );

   if (DUAL_WINDOW) begin : g_dual
      bootmap_window #(
         .ADDR_W   (ADDR_W),
         .IDX_W    (BOOT_AW),
         .BASE     (HIGH_BASE),
         .SIZE     (HIGH_SIZE),
         .IDX_BASE (HIGH_IDX)
      ) u_high_win (
         .addr (cpu_addr),
         .hit  (high_hit),
         .idx  (high_idx)
      );
   end else begin : g_single
      assign high_hit = 1'b0;
      assign high_idx = '0;
   end

   always_comb begin
      src       = (overlay_on && (low_hit || high_hit)) ? SRC_BOOT : SRC_CART;
      boot_sel  = (src == SRC_BOOT);
      boot_addr = high_hit ? high_idx : low_idx;
      cart_wr   = cpu_wr && !wdec.reg_hit;
   end

   bootmap_rdata_mux #(
      .DATA_W (DATA_W)
   ) u_mux (
      .src        (src),
      .rd         (cpu_rd),
      .boot_rdata (boot_rdata),
      .cart_rdata (cart_rdata),
      .rdata      (cpu_rdata),
      .cart_rd    (cart_rd)
   );
endmodule

// File: rtl/boot_overlay_decoder_chk.sv
module boot_overlay_decoder_chk #(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 8,
   parameter bit          DUAL       = 1'b1,
   parameter int unsigned LOW_BASE   = 0,
   parameter int unsigned LOW_SIZE   = 256,
   parameter int unsigned HIGH_BASE  = 16'h0200,
   parameter int unsigned REG_ADDR   = 16'hFF50,
   parameter int unsigned ARM_MASK   = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_wr,
   input logic [DATA_W-1:0] cpu_wdata,
   input logic              boot_sel,
   input logic              cart_rd,
   input logic              cart_wr,
   input logic              overlay_on
);
   localparam logic [ADDR_W-1:0] REG_A  = ADDR_W'(REG_ADDR);
   localparam logic [DATA_W-1:0] MASK_D = DATA_W'(ARM_MASK);
   localparam logic [ADDR_W:0]   LOW_LO = (ADDR_W+1)'(LOW_BASE);
   localparam logic [ADDR_W:0]   LOW_HI = (ADDR_W+1)'(LOW_BASE + LOW_SIZE);
   localparam logic [ADDR_W:0]   GAP_HI = (ADDR_W+1)'(HIGH_BASE);

   logic arm;
   logic in_low;
   logic in_gap;
   assign arm    = cpu_wr && (cpu_addr == REG_A) && ((cpu_wdata & MASK_D) != '0);
   assign in_low = ({1'b0, cpu_addr} >= LOW_LO) && ({1'b0, cpu_addr} < LOW_HI);
   assign in_gap = ({1'b0, cpu_addr} >= LOW_HI) && ({1'b0, cpu_addr} < GAP_HI);

   // R2
   low_window_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (overlay_on && in_low) |-> boot_sel);

   // R3
   unmap_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> !overlay_on);

   // R4
   no_spurious_unmap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (overlay_on && !arm) |=> overlay_on);

   // R5
   unmap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !overlay_on |=> !overlay_on);

   // R5
   unmapped_no_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !overlay_on |-> !boot_sel);

   // R8
   write_to_cart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr != REG_A) |-> cart_wr);

   // R10
   boot_blocks_cart_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      boot_sel |-> !cart_rd);

   if (DUAL) begin : g_gap
      // R7
      header_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_gap |-> !boot_sel);
   end
endmodule

bind boot_overlay_decoder boot_overlay_decoder_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .DUAL      (DUAL_WINDOW),
   .LOW_BASE  (LOW_BASE),
   .LOW_SIZE  (LOW_SIZE),
   .HIGH_BASE (HIGH_BASE),
   .REG_ADDR  (UNMAP_ADDR),
   .ARM_MASK  (UNMAP_MASK)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_addr   (cpu_addr),
   .cpu_wr     (cpu_wr),
   .cpu_wdata  (cpu_wdata),
   .boot_sel   (boot_sel),
   .cart_rd    (cart_rd),
   .cart_wr    (cart_wr),
   .overlay_on (overlay_on)
);

// File: tb/boot_overlay_decoder_bench.sv
module boot_overlay_decoder_bench;
   localparam int CLK_P = 10;

   typedef struct {
      logic [15:0] addr;
      logic        rd;
      logic        wr;
      logic [7:0]  rdata_d;
      logic [7:0]  rdata_s;
      logic        sel_d;
      logic        sel_s;
      logic        cwr;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        cpu_rd = 1'b0;
   logic        cpu_wr = 1'b0;
   logic [7:0]  cpu_wdata = '0;
   logic [7:0]  cart_rdata;
   logic [7:0]  rdata_d, rdata_s, brd_d, brd_s;
   logic [10:0] baddr_d, baddr_s;
   logic        sel_d, sel_s, crd_d, crd_s, cwr_d, cwr_s;

   int checks = 0;
   int errors = 0;
   bit model_on = 1'b1;
   exp_t q[$];

   function automatic logic [7:0] rom_f(input logic [10:0] i);
      return i[7:0] ^ {i[10:8], 5'h15};
   endfunction
   function automatic logic [7:0] cart_f(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'hC3;
   endfunction

   assign cart_rdata = cart_f(cpu_addr);
   assign brd_d = rom_f(baddr_d);
   assign brd_s = rom_f(baddr_s);

   always #(CLK_P/2) clk = ~clk;

   boot_overlay_decoder #(.DUAL_WINDOW(1'b1)) u_boot_overlay_decoder (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
      .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(rdata_d),
      .boot_addr(baddr_d), .boot_rdata(brd_d), .boot_sel(sel_d),
      .cart_rd(crd_d), .cart_wr(cwr_d), .cart_rdata(cart_rdata));

   boot_overlay_decoder #(.DUAL_WINDOW(1'b0)) u_boot_overlay_decoder_single (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
      .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(rdata_s),
      .boot_addr(baddr_s), .boot_rdata(brd_s), .boot_sel(sel_s),
      .cart_rd(crd_s), .cart_wr(cwr_s), .cart_rdata(cart_rdata));

   task automatic chk(input string tag, input string what, input logic [15:0] act,
                      input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // Drive one bus cycle and queue the expected results for that cycle
   task automatic drive(input logic [15:0] a, input logic rd, input logic wr,
                        input logic [7:0] wd, input string tag);
      exp_t e;
      logic in_lo, in_hi;
      logic [10:0] idx;
      @(negedge clk);
      cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = wd;
      in_lo = (a < 16'h0100);
      in_hi = (a >= 16'h0200) && (a < 16'h0900);
      idx   = in_lo ? a[10:0] : 11'(a - 16'h0100);
      e.addr = a; e.rd = rd; e.wr = wr; e.tag = tag;
      e.sel_d = model_on && (in_lo || in_hi);
      e.sel_s = model_on && in_lo;
      e.rdata_d = e.sel_d ? rom_f(idx) : cart_f(a);
      e.rdata_s = e.sel_s ? rom_f(idx) : cart_f(a);
      e.cwr = wr && (a != 16'hFF50);
      q.push_back(e);
      if (wr && a == 16'hFF50 && wd[0]) model_on = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cpu_rd = 1'b0; cpu_wr = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      model_on = 1'b1;
   endtask

   // Monitor: compare a quarter period after the driving edge
   always @(negedge clk) begin
      #(CLK_P/4);
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         chk(e.tag, "dual boot_sel", 16'(sel_d), 16'(e.sel_d));
         chk(e.tag, "single boot_sel", 16'(sel_s), 16'(e.sel_s));
         chk(e.tag, "dual rdata", 16'(rdata_d), 16'(e.rdata_d));
         chk(e.tag, "single rdata", 16'(rdata_s), 16'(e.rdata_s));
         chk(e.tag, "cart_wr", 16'(cwr_d), 16'(e.cwr));
         chk(e.tag, "single cart_wr", 16'(cwr_s), 16'(e.cwr));
         chk("R10", "dual cart_rd", 16'(crd_d), 16'(e.rd && !e.sel_d));
         chk("R10", "single cart_rd", 16'(crd_s), 16'(e.rd && !e.sel_s));
      end
   end

   initial begin
      #(CLK_P * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      drive(16'h0000, 1, 0, 8'h00, "R1");
      drive(16'h0050, 1, 0, 8'h00, "R2");
      drive(16'h00FF, 1, 0, 8'h00, "R2");
      drive(16'h0100, 1, 0, 8'h00, "R7");
      drive(16'h01FF, 1, 0, 8'h00, "R7");
      drive(16'h0200, 1, 0, 8'h00, "R6");
      drive(16'h08FF, 1, 0, 8'h00, "R6");
      drive(16'h0555, 1, 0, 8'h00, "R9");
      drive(16'h0900, 1, 0, 8'h00, "R7");
      drive(16'h0010, 0, 1, 8'h01, "R8");
      drive(16'h0300, 0, 1, 8'hFF, "R8");
      drive(16'h0010, 1, 0, 8'h00, "R4");
      drive(16'hFF51, 0, 1, 8'h01, "R4");
      drive(16'h0000, 1, 0, 8'h00, "R4");
      drive(16'hFF50, 0, 1, 8'hFE, "R4");
      drive(16'h0001, 1, 0, 8'h00, "R4");
      drive(16'hFF50, 0, 1, 8'h01, "R3");
      drive(16'h0000, 1, 0, 8'h00, "R3");
      drive(16'h00FF, 1, 0, 8'h00, "R3");
      drive(16'h0300, 1, 0, 8'h00, "R3");
      drive(16'hFF50, 0, 1, 8'h00, "R5");
      drive(16'h0000, 1, 0, 8'h00, "R5");
      drive(16'hFF50, 0, 1, 8'h01, "R5");
      drive(16'h0020, 1, 0, 8'h00, "R5");
      do_reset();
      drive(16'h0000, 1, 0, 8'h00, "R5");
      drive(16'h0700, 1, 0, 8'h00, "R6");
      drive(16'h0000, 0, 0, 8'h00, "R10");
      drive(16'h0180, 0, 0, 8'h00, "R10");
      @(negedge clk);
      cpu_rd = 1'b0; cpu_wr = 1'b0;
      @(negedge clk);
      @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule